// File: doc/BRIEF.md
# Seven-Segment Dual-Inverter PWM Sequencer

This block plays out one switching period of a drive in which two three-level inverters feed the opposite ends of an open-end motor winding. It is given the dwell times of the three vectors that synthesize the reference, a signed balancing factor, and the switching combination for each vector. From these it produces a symmetric seven-segment pattern. The pattern sets the three pole states of both inverters together and reports which segment is active.

The starting small vector has two redundant combinations. These push the DC-link midpoint in opposite directions. The block divides the dwell time of that vector between the two combinations according to the balancing factor. One combination occupies the outer segments and the other occupies the centre segment. A segment whose share works out to zero ticks is skipped. When the factor is at its limits, the pattern therefore shrinks to six or five segments. A period-start strobe latches all inputs at a period boundary. If the inputs cannot be carried out safely, the block raises an error and holds the zero vector for the whole period. This covers dwell times that overrun the period and any combination with common-mode content.

Top module: `dual_inv_seq7`

## Requirements
- R1: Within a period the active segment index runs 1 to 7 in order. Segments 1 and 7 apply `cmb_s1_i`, 2 and 6 apply `cmb_v2_i`, 3 and 5 apply `cmb_v3_i`, and 4 applies `cmb_s2_i`, all as latched at the period start.
- R2: With f as a signed value where 16384 means 1.0, the length of segment 4 is d4 = floor(t1·(16384−f)/32768). Segment 1 lasts floor((t1−d4)/2) ticks and segment 7 takes the remainder, so the three always add up to t1.
- R3: A factor above 16384 is treated as 16384, and one below −16384 is treated as −16384.
- R4: Segment 2 lasts floor(t2/2) ticks and segment 6 lasts the rest of t2. Segment 3 lasts floor(t3/2) ticks and segment 5 lasts the rest of t3.
- R5: A segment of zero length never appears on `seg_o`. At f = +1 segment 4 vanishes, and at f = −1 segments 1 and 7 vanish.
- R6: A period lasts `period_i` ticks, and a value of 0 gives one tick. Ticks after segment 7 and before the period ends show segment 0 with all poles at 0. When a period ends with no new strobe, the block goes idle.
- R7: If t1+t2+t3 exceeds `period_i`, `err_o` is high for that whole period, `seg_o` is 0 and all poles are 0. A sum exactly equal to the period is legal.
- R8: A combination is valid only when the pole sum of inverter 1 equals that of inverter 2 and no pole carries code 2'b10. Any invalid combination among the four latched ones leads to the R7 behaviour.
- R9: A strobe in mid-period is ignored, and inputs are latched only at a boundary. A strobe in the last tick of a period starts the next period on the following tick with the new values.
- R10: In reset and while idle, `seg_o` is 0, `err_o` is 0 and every pole is 0.
- R11: Each pole occupies two bits: 2'b01 is +Vdc/2, 2'b00 is 0 and 2'b11 is −Vdc/2. Bits [1:0], [3:2] and [5:4] hold phases a, b and c. A combination holds inverter 1 in bits [5:0] and inverter 2 in bits [11:6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one tick per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Period-start strobe |
| period_i | input | 16 | Period length in ticks |
| t1_i | input | 16 | Dwell time of the starting small vector |
| t2_i | input | 16 | Dwell time of the second vector |
| t3_i | input | 16 | Dwell time of the third vector |
| f_i | input | 16 | Signed balancing factor, 16384 = 1.0 |
| cmb_s1_i | input | 12 | Starting vector combination for the outer segments |
| cmb_s2_i | input | 12 | Starting vector combination for the centre segment |
| cmb_v2_i | input | 12 | Second vector combination |
| cmb_v3_i | input | 12 | Third vector combination |
| inv1_o | output | 6 | Pole states of inverter 1 |
| inv2_o | output | 6 | Pole states of inverter 2 |
| seg_o | output | 3 | Active segment, 0 when none |
| err_o | output | 1 | Period rejected |

## Verification
The hardest case to reach is the hand-off at a period boundary. New values must take effect exactly one tick after the final tick, with no idle gap, while a strobe one tick earlier must change nothing. The bench raises the strobe on the last tick of a running period, with a different set of times and factor. It checks every tick of both periods. In a separate run it pokes the strobe with altered inputs in mid-period and confirms that the pattern stays the same. Degenerate patterns at both limits of the factor, and overrun by exactly one tick, are driven directly with chosen dwell times.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int NPOLE = 3;
  localparam int NSEG  = 7;

  typedef logic [1:0] pole_t;
  localparam pole_t P_POS  = 2'b01;
  localparam pole_t P_ZERO = 2'b00;
  localparam pole_t P_NEG  = 2'b11;
  localparam pole_t P_BAD  = 2'b10;

  typedef struct packed {
    pole_t [NPOLE-1:0] inv2;
    pole_t [NPOLE-1:0] inv1;
  } combo_t;

  localparam int CW = $bits(combo_t);

  function automatic logic signed [3:0] pole_sum(input pole_t [NPOLE-1:0] p);
    logic signed [3:0] s;
    s = '0;
    for (int i = 0; i < NPOLE; i++) begin
      case (p[i])
        P_POS:          s = s + 4'sd1;
        P_NEG:          s = s - 4'sd1;
        P_ZERO, P_BAD:  s = s;
        default:        s = s;
      endcase
    end
    return s;
  endfunction

  function automatic logic pole_bad(input pole_t [NPOLE-1:0] p);
    logic b;
    b = 1'b0;
    for (int i = 0; i < NPOLE; i++) b = b | (p[i] == P_BAD);
    return b;
  endfunction
endpackage

// File: rtl/dis_split.sv
module dis_split
  import dis_pkg::*;
#(
  parameter int TW   = 16,
  parameter int FW   = 16,
  parameter int FRAC = 14
) (
  input  logic [TW-1:0]            t1_i,
  input  logic [TW-1:0]            t2_i,
  input  logic [TW-1:0]            t3_i,
  input  logic signed [FW-1:0]     f_i,
  output logic [NSEG-1:0][TW-1:0]  dur_o
);
  localparam int PW = TW + FRAC + 2;
  localparam logic signed [FW-1:0] F_HI = FW'(2**FRAC);
  localparam logic signed [FW-1:0] F_LO = -F_HI;

  logic signed [FW-1:0] f_c;
  logic [FRAC+1:0]      w;
  logic [PW-1:0]        prod;
  logic [TW-1:0]        d_ctr, rem, d_out;

  always_comb begin
    if (f_i > F_HI)      f_c = F_HI;
    else if (f_i < F_LO) f_c = F_LO;
    else                 f_c = f_i;
    // weight of the centre combination: (1 - f) in Q(FRAC), range 0..2
    w     = (FRAC+2)'((2**FRAC) - int'(f_c));
    prod  = PW'(t1_i) * PW'(w);
    d_ctr = TW'(prod >> (FRAC + 1));
    rem   = t1_i - d_ctr;
    d_out = rem >> 1;
    dur_o[0] = d_out;
    dur_o[1] = t2_i >> 1;
    dur_o[2] = t3_i >> 1;
    dur_o[3] = d_ctr;
    dur_o[4] = t3_i - (t3_i >> 1);
    dur_o[5] = t2_i - (t2_i >> 1);
    dur_o[6] = rem - d_out;
  end
endmodule

// File: rtl/dis_cm.sv
module dis_cm
  import dis_pkg::*;
(
  input  combo_t c_i,
  output logic   ok_o
);
  assign ok_o = !pole_bad(c_i.inv1) && !pole_bad(c_i.inv2) &&
                (pole_sum(c_i.inv1) == pole_sum(c_i.inv2));
endmodule

// File: rtl/dis_sched.sv
module dis_sched
  import dis_pkg::*;
#(
  parameter int TW = 16,
  localparam int SW = $clog2(NSEG + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [TW-1:0]            period_i,
  input  logic [NSEG-1:0][TW-1:0]  dur_i,
  input  logic                     cm_bad_i,
  output logic                     load_o,
  output logic [SW-1:0]            seg_o,
  output logic                     err_o
);
  localparam int BW = TW + 2;

  logic [NSEG-1:0][BW-1:0] bnd_d, bnd_q;
  logic [TW-1:0] cnt_q, per_q;
  logic busy_q, err_q, last, over;

  for (genvar k = 0; k < NSEG; k++) begin : g_cum
    if (k == 0) begin : g_first
      assign bnd_d[k] = BW'(dur_i[k]);
    end else begin : g_next
      assign bnd_d[k] = bnd_d[k-1] + BW'(dur_i[k]);
    end
  end

  assign over   = bnd_d[NSEG-1] > BW'(period_i);
  assign last   = busy_q && (((TW+1)'(cnt_q) + 1'b1) >= (TW+1)'(per_q));
  assign load_o = start_i && (!busy_q || last);
  assign err_o  = busy_q && err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
      per_q  <= '0;
      bnd_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      err_q  <= over | cm_bad_i;
      cnt_q  <= '0;
      per_q  <= period_i;
      bnd_q  <= bnd_d;
    end else if (last) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // lowest segment whose end lies beyond the tick; empty segments fall through
  always_comb begin
    seg_o = '0;
    if (busy_q && !err_q) begin
      for (int k = NSEG - 1; k >= 0; k--) begin
        if (BW'(cnt_q) < bnd_q[k]) seg_o = SW'(k + 1);
      end
    end
  end

  AST_SEG_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && !$past(load_o) && seg_o != '0) |-> (seg_o >= $past(seg_o))); // R1
  AST_PER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last) |=> ($stable(per_q) && $stable(bnd_q))); // R9
  AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && !load_o) |=> (!busy_q && seg_o == '0 && !err_o)); // R6
endmodule

// File: rtl/dual_inv_seq7.sv
module dual_inv_seq7
  import dis_pkg::*;
#(
  parameter int TW   = 16,
  parameter int FW   = 16,
  parameter int FRAC = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [TW-1:0]        period_i,
  input  logic [TW-1:0]        t1_i,
  input  logic [TW-1:0]        t2_i,
  input  logic [TW-1:0]        t3_i,
  input  logic signed [FW-1:0] f_i,
  input  logic [CW-1:0]        cmb_s1_i,
  input  logic [CW-1:0]        cmb_s2_i,
  input  logic [CW-1:0]        cmb_v2_i,
  input  logic [CW-1:0]        cmb_v3_i,
  output logic [2*NPOLE-1:0]   inv1_o,
  output logic [2*NPOLE-1:0]   inv2_o,
  output logic [2:0]           seg_o,
  output logic                 err_o
);
  localparam int NCMB = 4;

  logic [NSEG-1:0][TW-1:0] dur;
  combo_t [NCMB-1:0] cmb_in, cmb_q;
  logic [NCMB-1:0]   cm_ok;
  logic              load;
  combo_t            sel;

  assign cmb_in[0] = combo_t'(cmb_s1_i);
  assign cmb_in[1] = combo_t'(cmb_s2_i);
  assign cmb_in[2] = combo_t'(cmb_v2_i);
  assign cmb_in[3] = combo_t'(cmb_v3_i);

  dis_split #(.TW(TW), .FW(FW), .FRAC(FRAC)) u_split (
    .t1_i (t1_i),
    .t2_i (t2_i),
    .t3_i (t3_i),
    .f_i  (f_i),
    .dur_o(dur)
  );

  for (genvar g = 0; g < NCMB; g++) begin : g_chk
    dis_cm u_cm (
      .c_i (cmb_in[g]),
      .ok_o(cm_ok[g])
    );
  end

  dis_sched #(.TW(TW)) u_sched (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .period_i(period_i),
    .dur_i   (dur),
    .cm_bad_i(~&cm_ok),
    .load_o  (load),
    .seg_o   (seg_o),
    .err_o   (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmb_q <= '0;
    else if (load) cmb_q <= cmb_in;
  end

  always_comb begin
    case (seg_o)
      3'd1, 3'd7: sel = cmb_q[0];
      3'd4:       sel = cmb_q[1];
      3'd2, 3'd6: sel = cmb_q[2];
      3'd3, 3'd5: sel = cmb_q[3];
      default:    sel = '0;
    endcase
  end

  assign inv1_o = sel.inv1;
  assign inv2_o = sel.inv2;

  AST_CM_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pole_sum(inv1_o) == pole_sum(inv2_o)); // R8
  AST_NO_BAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pole_bad(inv1_o) && !pole_bad(inv2_o)); // R11
  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (seg_o == 3'd0 && inv1_o == '0 && inv2_o == '0)); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_o == 3'd0) |-> (inv1_o == '0 && inv2_o == '0)); // R6
  AST_SPLIT_T1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((TW+2)'(dur[0]) + (TW+2)'(dur[3]) + (TW+2)'(dur[6])) == (TW+2)'(t1_i)); // R2
endmodule

// File: tb/dual_inv_seq7_test.sv
`timescale 1ns/1ps
module dual_inv_seq7_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [15:0] period_i = '0, t1_i = '0, t2_i = '0, t3_i = '0;
  logic signed [15:0] f_i = '0;
  logic [11:0] cmb_s1_i = '0, cmb_s2_i = '0, cmb_v2_i = '0, cmb_v3_i = '0;
  logic [5:0] inv1_o, inv2_o;
  logic [2:0] seg_o;
  logic err_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  int e_b[7];
  int e_per;
  bit e_err;
  logic [11:0] e_cmb[4];

  always #2 clk = ~clk;

  dual_inv_seq7 uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .period_i(period_i),
    .t1_i(t1_i), .t2_i(t2_i), .t3_i(t3_i), .f_i(f_i),
    .cmb_s1_i(cmb_s1_i), .cmb_s2_i(cmb_s2_i), .cmb_v2_i(cmb_v2_i), .cmb_v3_i(cmb_v3_i),
    .inv1_o(inv1_o), .inv2_o(inv2_o), .seg_o(seg_o), .err_o(err_o)
  );

  function automatic logic [1:0] pc(input int v);
    return (v > 0) ? 2'b01 : (v < 0) ? 2'b11 : 2'b00;
  endfunction

  function automatic logic [11:0] mk(input int a1, input int b1, input int c1,
                                     input int a2, input int b2, input int c2);
    return {pc(c2), pc(b2), pc(a2), pc(c1), pc(b1), pc(a1)};
  endfunction

  function automatic bit valid(input logic [11:0] c);
    int s1, s2;
    bit ok;
    s1 = 0; s2 = 0; ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      logic [1:0] p;
      p = c[2*i +: 2];
      if (p == 2'b10) ok = 1'b0;
      if (i < 3) s1 += (p == 2'b01) ? 1 : (p == 2'b11) ? -1 : 0;
      else       s2 += (p == 2'b01) ? 1 : (p == 2'b11) ? -1 : 0;
    end
    return ok && (s1 == s2);
  endfunction

  localparam logic [11:0] C_S1 = 12'b000000_110001;
  localparam logic [11:0] C_S2 = 12'b010011_000000;
  localparam logic [11:0] C_V2 = 12'b010011_110001;
  localparam logic [11:0] C_V3 = 12'b110100_001101;

  task automatic set_vec(input int t1, input int t2, input int t3, input int f,
                         input int per, input logic [11:0] v3);
    int fc, d[7], s;
    t1_i = 16'(t1); t2_i = 16'(t2); t3_i = 16'(t3); f_i = 16'(f); period_i = 16'(per);
    cmb_s1_i = C_S1; cmb_s2_i = C_S2; cmb_v2_i = C_V2; cmb_v3_i = v3;
    e_cmb[0] = C_S1; e_cmb[1] = C_S2; e_cmb[2] = C_V2; e_cmb[3] = v3;
    fc = (f > 16384) ? 16384 : (f < -16384) ? -16384 : f;
    d[3] = (t1 * (16384 - fc)) / 32768;
    d[0] = (t1 - d[3]) / 2;
    d[6] = t1 - d[3] - d[0];
    d[1] = t2 / 2; d[5] = t2 - d[1];
    d[2] = t3 / 2; d[4] = t3 - d[2];
    s = 0;
    for (int k = 0; k < 7; k++) begin s += d[k]; e_b[k] = s; end
    e_per = (per == 0) ? 1 : per;
    e_err = (s > per) || !valid(C_S1) || !valid(C_S2) || !valid(C_V2) || !valid(v3);
  endtask

  function automatic int exp_seg(input int k);
    if (e_err) return 0;
    for (int j = 0; j < 7; j++) if (k < e_b[j]) return j + 1;
    return 0;
  endfunction

  function automatic logic [11:0] exp_cmb(input int s);
    case (s)
      1, 7: return e_cmb[0];
      4:    return e_cmb[1];
      2, 6: return e_cmb[2];
      3, 5: return e_cmb[3];
      default: return 12'h000;
    endcase
  endfunction

  task automatic chk(input string req, input int es, input logic [11:0] ec, input bit ee);
    checks++;
    if (seg_o !== 3'(es) || {inv2_o, inv1_o} !== ec || err_o !== ee) begin
      fails++;
      $display("FAIL %s: seg=%0d poles=%h err=%b, expected seg=%0d poles=%h err=%b",
               req, seg_o, {inv2_o, inv1_o}, err_o, es, ec, ee);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, 0, 12'h000, 1'b0);
  endtask

  task automatic launch();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  // mode 0: plain, 1: mid-period poke, 2: chain into (nt1..nper) on last tick
  task automatic play(input string req, input int mode, input int nt1, input int nt2,
                      input int nt3, input int nf, input int nper);
    int n;
    n = e_per;
    for (int k = 0; k < n; k++) begin
      int s;
      s = exp_seg(k);
      chk(req, s, exp_cmb(s), e_err);
      if (mode == 1 && k == 3) begin
        start_i = 1'b1; t1_i = 16'd1; t2_i = 16'd0; f_i = 16'sd9000;
        cmb_v2_i = C_S1; period_i = 16'd5;
      end
      if (mode == 2 && k == n - 1) begin
        set_vec(nt1, nt2, nt3, nf, nper, C_V3);
        start_i = 1'b1;
      end
      @(negedge clk); start_i = 1'b0;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk_idle("R10 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_idle("R10 idle after reset");
  endtask

  task automatic t_basic();
    set_vec(8, 6, 10, 0, 30, C_V3); launch();
    play("R1 R4 R11 f=0 pattern", 0, 0, 0, 0, 0, 0);
    chk_idle("R6 idle after period");
  endtask

  task automatic t_frac();
    set_vec(10, 7, 5, 8192, 25, C_V3); launch();
    play("R2 R4 f=+0.5 odd times", 0, 0, 0, 0, 0, 0);
    set_vec(13, 3, 4, -5000, 22, C_V3); launch();
    play("R2 negative f", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_limits();
    set_vec(9, 4, 6, 16384, 20, C_V3); launch();
    play("R5 f=+1 centre gone", 0, 0, 0, 0, 0, 0);
    set_vec(9, 4, 6, -16384, 20, C_V3); launch();
    play("R5 f=-1 outer gone", 0, 0, 0, 0, 0, 0);
    set_vec(0, 0, 3, 0, 6, C_V3); launch();
    play("R5 zero t1 and t2", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_clamp();
    set_vec(11, 2, 2, 30000, 16, C_V3); launch();
    play("R3 f clamp high", 0, 0, 0, 0, 0, 0);
    set_vec(11, 2, 2, -32768, 16, C_V3); launch();
    play("R3 f clamp low", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_overrun();
    set_vec(10, 10, 10, 0, 30, C_V3); launch();
    play("R7 sum equals period", 0, 0, 0, 0, 0, 0);
    set_vec(10, 10, 11, 0, 30, C_V3); launch();
    play("R7 overrun by one", 0, 0, 0, 0, 0, 0);
    chk_idle("R7 error clears at end");
  endtask

  task automatic t_cm();
    set_vec(4, 4, 4, 0, 14, mk(1, 0, 0, 0, 0, 0)); launch();
    play("R8 unequal pole sums", 0, 0, 0, 0, 0, 0);
    set_vec(4, 4, 4, 0, 14, 12'b000000_100000); launch();
    play("R8 illegal pole code", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_bound();
    set_vec(8, 8, 8, 0, 30, C_V3); launch();
    play("R9 mid-period strobe ignored", 1, 0, 0, 0, 0, 0);
    chk_idle("R9 idle after poked period");
    set_vec(4, 4, 4, 0, 20, C_V3); launch();
    play("R9 first chained period", 2, 6, 2, 2, -8192, 12);
    play("R9 second chained period", 0, 0, 0, 0, 0, 0);
    chk_idle("R9 idle after chain");
  endtask

  task automatic t_per0();
    set_vec(1, 0, 0, 0, 0, C_V3); launch();
    play("R6 zero period is one tick", 0, 0, 0, 0, 0, 0);
    chk_idle("R6 idle after one tick");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_frac();
    t_limits();
    t_clamp();
    t_overrun();
    t_cm();
    t_bound();
    t_per0();
    repeat (2) @(negedge clk);
    chk_idle("R10 final idle");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule